// File: doc/BRIEF.md
# Two-Slot Fragmented Adder

This block adds two wide unsigned operands on a single adder that is only half the operand width. The addition is split into a low fragment and a high fragment that run in two separate execution slots. The slots are started by two request pulses and may be separated by any number of idle cycles. The low slot adds the lower halves. Its result is on the output in the same cycle, so a following operation can use it at once. The low slot also saves its carry and the upper operand halves. The high slot later adds those stored upper halves together with the saved carry.

Between the slots only the upper operand halves and one carry bit are held. The bits that were already summed are dropped after their slot. With the default fragment width of 12, the block forms a 24-bit sum and a final carry.

Top module: `frag_adder`

## Requirements
- R1: In a cycle where `lowReq` is 1, `sumLo` equals (`opA[11:0]` + `opB[11:0]`) mod 4096 in that same cycle and `loValid` is 1. From the next cycle on, `sumLo` keeps that value until the next low slot.
- R2: From the cycle after a low slot, `carryHeld` equals the carry out (bit 12) of that low addition.
- R3: After a high slot is accepted, the results appear one cycle later. `sumHi` equals (A[23:12] + B[23:12] + `carryHeld`) mod 4096, `carryOut` is the carry of that addition, and `hiValid` is 1. Here A and B are the operands captured at the low slot. {`carryOut`,`sumHi`,`sumLo`} then equals A + B.
- R4: The upper operand bits are captured at the low slot. The values on `opA`/`opB` during idle cycles and during the high slot have no effect on any output.
- R5: Any number of idle cycles may lie between the two slots. During them `carryHeld`, `sumLo`, `loValid`, `sumHi`, `hiValid` and `carryOut` do not change.
- R6: A `highReq` is ignored and leaves every output unchanged when no low fragment is pending. This holds after reset, and also after a high slot has already completed.
- R7: A low slot clears `hiValid` and `carryOut` to 0 in the following cycle. `loValid` stays 1 from the first low slot until reset.
- R8: When `lowReq` and `highReq` are both 1 in the same cycle, the low slot runs and the high request is ignored.
- R9: After reset, `loValid`, `hiValid`, `carryOut`, `carryHeld`, `sumLo` and `sumHi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 24 | First operand |
| opB | input | 24 | Second operand |
| lowReq | input | 1 | Run the low fragment in this cycle |
| highReq | input | 1 | Run the high fragment in this cycle |
| sumLo | output | 12 | Low half of the sum (same cycle during a low slot) |
| loValid | output | 1 | Low half is valid |
| sumHi | output | 12 | High half of the sum |
| hiValid | output | 1 | High half is valid |
| carryOut | output | 1 | Final carry of the full addition |
| carryHeld | output | 1 | Carry saved between the two slots |

## Verification
The bench builds the block with its default fragment width of 12, so the operands are 24 bits wide. At this width the carry boundaries can be reached directly with operands such as all-ones plus one and all-ones plus all-ones. A mix of pseudo-random operands with varying idle gaps then covers the general case. The stimulus also changes the operand inputs while a high fragment is pending, and it issues simultaneous and orphaned high requests.

// File: rtl/frag_adder_pkg.sv
package frag_adder_pkg;
  typedef struct packed {
    logic runLow;
    logic runHigh;
  } fragStrobe_t;
endpackage

// File: rtl/frag_adder_ctrl.sv
module frag_adder_ctrl
  import frag_adder_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowReq,
  input  logic        highReq,
  output fragStrobe_t strb
);
  logic pending;

  always_comb begin
    strb.runLow  = lowReq;
    strb.runHigh = highReq & pending & ~lowReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pending <= 1'b0;
    else if (strb.runLow)  pending <= 1'b1;
    else if (strb.runHigh) pending <= 1'b0;
  end

  assert_high_needs_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.runHigh |-> pending);
  assert_low_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    lowReq |-> !strb.runHigh);
endmodule

// File: rtl/frag_adder_dp.sv
module frag_adder_dp
  import frag_adder_pkg::*;
#(
  parameter int FRAG_W = 12,
  localparam int FULL_W = 2 * FRAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fragStrobe_t       strb,
  input  logic [FULL_W-1:0] opA,
  input  logic [FULL_W-1:0] opB,
  output logic [FRAG_W-1:0] sumLo,
  output logic              loValid,
  output logic [FRAG_W-1:0] sumHi,
  output logic              hiValid,
  output logic              carryOut,
  output logic              carryHeld
);
  logic [FRAG_W-1:0] hiA, hiB, loReg, hiReg;
  logic              carryReg, loDone, hiDone, coutReg;
  logic [FRAG_W-1:0] aIn, bIn;
  logic              cIn;
  logic [FRAG_W:0]   addRes;

  // shared fragment adder
  always_comb begin
    aIn    = strb.runHigh ? hiA : opA[FRAG_W-1:0];
    bIn    = strb.runHigh ? hiB : opB[FRAG_W-1:0];
    cIn    = strb.runHigh ? carryReg : 1'b0;
    addRes = {1'b0, aIn} + {1'b0, bIn} + {{FRAG_W{1'b0}}, cIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiA      <= '0;
      hiB      <= '0;
      carryReg <= 1'b0;
      loReg    <= '0;
      loDone   <= 1'b0;
      hiReg    <= '0;
      hiDone   <= 1'b0;
      coutReg  <= 1'b0;
    end else if (strb.runLow) begin
      hiA      <= opA[FULL_W-1:FRAG_W];
      hiB      <= opB[FULL_W-1:FRAG_W];
      carryReg <= addRes[FRAG_W];
      loReg    <= addRes[FRAG_W-1:0];
      loDone   <= 1'b1;
      hiDone   <= 1'b0;
      coutReg  <= 1'b0;
    end else if (strb.runHigh) begin
      hiReg    <= addRes[FRAG_W-1:0];
      coutReg  <= addRes[FRAG_W];
      hiDone   <= 1'b1;
    end
  end

  always_comb begin
    sumLo     = strb.runLow ? addRes[FRAG_W-1:0] : loReg;
    loValid   = strb.runLow | loDone;
    sumHi     = hiReg;
    hiValid   = hiDone;
    carryOut  = coutReg;
    carryHeld = carryReg;
  end

  assert_low_same_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.runLow |-> (loValid && sumLo == FRAG_W'(opA[FRAG_W-1:0] + opB[FRAG_W-1:0])));
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runLow && !strb.runHigh) |=> ($stable(carryHeld) && $stable(hiA) && $stable(hiB)
                                         && $stable(sumHi) && $stable(hiValid)));
  assert_clear_on_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.runLow |=> (!hiValid && !carryOut && loValid));
  assert_high_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiValid) |-> $past(strb.runHigh));
endmodule

// File: rtl/frag_adder.sv
module frag_adder
  import frag_adder_pkg::*;
#(
  parameter int FRAG_W = 12,
  localparam int FULL_W = 2 * FRAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FULL_W-1:0] opA,
  input  logic [FULL_W-1:0] opB,
  input  logic              lowReq,
  input  logic              highReq,
  output logic [FRAG_W-1:0] sumLo,
  output logic              loValid,
  output logic [FRAG_W-1:0] sumHi,
  output logic              hiValid,
  output logic              carryOut,
  output logic              carryHeld
);
  fragStrobe_t strb;

  frag_adder_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lowReq(lowReq), .highReq(highReq), .strb(strb)
  );

  frag_adder_dp #(.FRAG_W(FRAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .sumLo(sumLo), .loValid(loValid), .sumHi(sumHi), .hiValid(hiValid),
    .carryOut(carryOut), .carryHeld(carryHeld)
  );
endmodule

// File: tb/frag_adder_test.sv
module frag_adder_test;
  localparam int FW = 12;
  localparam int MASK = (1 << FW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2*FW-1:0] opA = '0, opB = '0;
  logic          lowReq = 1'b0, highReq = 1'b0;
  logic [FW-1:0] sumLo, sumHi;
  logic          loValid, hiValid, carryOut, carryHeld;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int  mLo = 0, mHi = 0, mHiA = 0, mHiB = 0;
  int  mCarry = 0, mCout = 0;
  bit  mLoV = 0, mHiV = 0, mPend = 0;
  longint mFull = 0;

  always #10 clk = ~clk;

  frag_adder uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .lowReq(lowReq), .highReq(highReq),
    .sumLo(sumLo), .loValid(loValid), .sumHi(sumHi), .hiValid(hiValid),
    .carryOut(carryOut), .carryHeld(carryHeld)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic step(bit lo, bit hi, int a, int b, string tag);
    int lsum;
    int hsum;
    @(negedge clk);
    lowReq = lo; highReq = hi; opA = a[2*FW-1:0]; opB = b[2*FW-1:0];
    #1;
    lsum = (a & MASK) + (b & MASK);
    chk({tag, " R1 sumLo"}, int'(sumLo), lo ? (lsum & MASK) : mLo);
    chk({tag, " R7 loValid"}, int'(loValid), int'(lo | mLoV));
    chk({tag, " R3 sumHi"}, int'(sumHi), mHi);
    chk({tag, " R3 hiValid"}, int'(hiValid), int'(mHiV));
    chk({tag, " R3 carryOut"}, int'(carryOut), mCout);
    chk({tag, " R2 carryHeld"}, int'(carryHeld), mCarry);
    @(posedge clk);
    if (lo) begin
      mLo = lsum & MASK; mLoV = 1; mHiV = 0; mCout = 0;
      mCarry = lsum >> FW; mPend = 1;
      mHiA = (a >> FW) & MASK; mHiB = (b >> FW) & MASK;
      mFull = longint'(a & 24'hFFFFFF) + longint'(b & 24'hFFFFFF);
    end else if (hi && mPend) begin
      hsum = mHiA + mHiB + mCarry;
      mHi = hsum & MASK; mCout = hsum >> FW; mHiV = 1; mPend = 0;
    end
  endtask

  task automatic checkFull(string tag);
    longint got;
    @(negedge clk); #1;
    got = (longint'(carryOut) << (2*FW)) | (longint'(sumHi) << FW) | longint'(sumLo);
    chk({tag, " R3 full sum"}, int'(got), int'(mFull));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234567;
    repeat (2) @(posedge clk);
    #3 rstN = 1'b1;
    // R9 reset state
    step(0, 0, 0, 0, "R9 reset");
    // R6 orphan high after reset
    step(0, 1, 24'h123456, 24'h654321, "R6 orphan");
    step(0, 0, 0, 0, "R6 after orphan");
    // low carry boundary, R2 R4 R5: inputs change during gap
    step(1, 0, 24'h000FFF, 24'h000001, "R2 low carry");
    step(0, 0, 24'hFFFFFF, 24'hFFFFFF, "R4 idle junk");
    step(0, 0, 24'hABCDEF, 24'h111111, "R5 idle");
    step(0, 0, 24'h000000, 24'h777777, "R5 idle");
    step(0, 1, 24'hFFF000, 24'hFFF000, "R3 high");
    checkFull("R3 carry chain");
    // R6 second high ignored
    step(0, 1, 24'h0, 24'h0, "R6 second high");
    step(0, 0, 0, 0, "R6 stable");
    // maximum operands, back-to-back slots
    step(1, 0, 24'hFFFFFF, 24'hFFFFFF, "R3 max low");
    step(0, 1, 0, 0, "R3 max high");
    checkFull("R3 max full");
    // R7 new low clears high half
    step(1, 0, 24'h00A001, 24'h00B002, "R7 new low");
    step(0, 0, 0, 0, "R7 cleared");
    // R8 simultaneous requests
    step(1, 1, 24'h800800, 24'h800800, "R8 both");
    step(0, 0, 0, 0, "R8 still pending");
    step(0, 1, 0, 0, "R8 high");
    checkFull("R8 full");
    // pseudo-random operands with varying gaps
    for (int i = 0; i < 200; i++) begin
      int a, b, gap;
      seed = seed * 1103515245 + 12345; a = (seed >>> 4) & 24'hFFFFFF;
      seed = seed * 1103515245 + 12345; b = (seed >>> 4) & 24'hFFFFFF;
      gap = (seed >>> 20) & 7;
      step(1, 0, a, b, "R1 rand low");
      for (int g = 0; g < gap; g++) step(0, 0, b, a, "R5 rand gap");
      step(0, 1, a ^ b, a, "R4 rand high");
      checkFull("R3 rand full");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule